// File: doc/BRIEF.md
# Three-Level Summary Interrupt Controller

This block collects a set of raw interrupt lines, 64 by default, and presents them to a processor through a byte-wide register port. Lines come in groups of eight called blocks, and eight blocks make up one master group. Each line has its own trigger setting: rising edge, falling edge, both edges, active-high level or active-low level, or disabled. A detected event sets a sticky pending bit for that line.

Software does not address the per-line state directly. It first writes a block number into a block-select register. It then reads that block's pending bits, its synchronised live levels, or the setting of one line through three shared windows. Writes to the same shared configuration window change a line's setting. Pending activity is summarised in two layers above the blocks. A master status register holds one bit per block. A root register holds one bit per master. A single interrupt output is asserted while any master is flagged.

Register offsets from `BASE_ADDR`: 0 root, 1 to 4 master status 0 to 3, 5 block select, 6 pending status, 7 line configuration, 8 live level. All other offsets read as zero and ignore writes.

Top module: `irq_tree_ctrl`

## Requirements
- R1: Reads return the register at the offset listed above. Root bit 0 always reads 0, and master group m is flagged at root bit m+1.
- R2: Line n belongs to block n/8 at bit n%8. Reading offset 6 returns the pending bits of the block most recently written to offset 5.
- R3: Reading offset 8 returns the selected block's line levels after two-flop synchronisation. A change on `line_in` shows there two clock edges later.
- R4: A write to offset 7 whose bit 7 is 0 changes no line setting and clears nothing. It still updates the line index used for readback.
- R5: A write to offset 7 uses bit 0 for level mode, bit 1 to mask the falling edge or low level, bit 2 to mask the rising edge or high level, bit 3 to clear pending, and bits 6:4 to pick the line within the selected block. Offset 7 reads {0, index, 0, bit2, bit1, bit0} for the line named by the index of the last write to offset 7. After reset every line reads masked on both sides in edge mode (0x06 plus index<<4), and the index is 0.
- R6: In edge mode, a synchronised 0-to-1 transition sets pending when the rising mask is clear, and a 1-to-0 transition sets pending when the falling mask is clear. Pending appears three edges after the input change.
- R7: In level mode, pending is set on every cycle the synchronised level is high with the rising mask clear, or low with the falling mask clear.
- R8: Pending bits stay set until a valid configuration write with bit 3 set addresses that line. If an event for that line is detected in the same cycle as the clear, the event wins.
- R9: Master status register m bit i is 1 when block m*8+i has a pending line that is not masked on both sides. A pending line with both masks set stays pending but is not summarised.
- R10: `irq_out` is 1 exactly when the root register is nonzero.
- R11: When the block select holds a number at or above the implemented block count, offsets 6, 7 and 8 read zero, and configuration writes affect no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for this cycle |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| line_in | input | NUM_LINES | Raw interrupt lines, asynchronous |
| irq_out | output | 1 | Summary interrupt |

## Verification
The checker assumes that `reg_addr` is stable for the whole cycle in which `reg_rdata` is observed. It also assumes that `rst_n` is held low from time zero until after the first clock edge, so that the stickiness property starts from a known empty pending set. The bench drives all inputs, including the raw lines, only on the falling clock edge. It samples one time unit later, which keeps every read inside the combinational window the checker relies on. Directed sequences place clears before, on, and after a detected edge. A seeded random phase also selects blocks beyond the implemented range, so the out-of-range rules are exercised under traffic.

// File: rtl/irq_tree_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the three-level interrupt controller.
// Assumes byte-wide registers and eight lines per block, eight blocks per master.
package irq_tree_pkg;
    localparam int LINES_PER_BLK = 8;
    localparam int NUM_MREG      = 4;

    // Register offsets from the base address
    localparam int OFS_ROOT  = 0;
    localparam int OFS_MSTAT = 1;
    localparam int OFS_BSEL  = 5;
    localparam int OFS_PEND  = 6;
    localparam int OFS_CFG   = 7;
    localparam int OFS_LIVE  = 8;

    // Bit positions inside a configuration write
    localparam int CB_LVL = 0;
    localparam int CB_MFE = 1;
    localparam int CB_MRE = 2;
    localparam int CB_CLR = 3;
    localparam int CB_IDX = 4;
    localparam int CB_WE  = 7;

    typedef struct packed {
        logic lvl;
        logic m_fe;
        logic m_re;
    } line_cfg_t;

    localparam line_cfg_t CFG_RESET = '{lvl: 1'b0, m_fe: 1'b1, m_re: 1'b1};
endpackage

// File: rtl/irq_tree_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser bank with an extra history stage for edge detection.
// Assumes line inputs are asynchronous; all outputs clear on reset.
module irq_tree_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta_q;

    // Shift raw lines through two capture stages and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
            q_prev <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
            q_prev <= q;
        end
    end
endmodule

// File: rtl/irq_tree_line.sv
`timescale 1ns/1ps
// One interrupt line: stored trigger setting, event detection and sticky pending.
// Assumes lvl_now/lvl_prev are synchronised; a clear loses to a same-cycle event.
module irq_tree_line
    import irq_tree_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl_now,
    input  logic      lvl_prev,
    input  logic      wr_hit,
    input  line_cfg_t wr_cfg,
    input  logic      wr_clr,
    output line_cfg_t cfg_q,
    output logic      pend_q,
    output logic      enabled
);
    logic hit_evt;

    // Decide whether this cycle carries a qualifying event
    always_comb begin
        if (cfg_q.lvl)
            hit_evt = (lvl_now & ~cfg_q.m_re) | (~lvl_now & ~cfg_q.m_fe);
        else
            hit_evt = (lvl_now & ~lvl_prev & ~cfg_q.m_re)
                    | (~lvl_now & lvl_prev & ~cfg_q.m_fe);
    end

    // Hold the trigger setting written by software
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= CFG_RESET;
        else if (wr_hit)
            cfg_q <= wr_cfg;
    end

    // Sticky pending bit; new event overrides a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= hit_evt | (pend_q & ~(wr_hit & wr_clr));
    end

    assign enabled = ~(cfg_q.m_re & cfg_q.m_fe);
endmodule

// File: rtl/irq_tree_summary.sv
`timescale 1ns/1ps
// Folds per-block activity into master status bytes and the root byte.
// Assumes at most NUM_MREG*8 blocks; root bit 0 is reserved, master m at bit m+1.
module irq_tree_summary
    import irq_tree_pkg::*;
#(
    parameter int NUM_BLKS = 8
) (
    input  logic [NUM_BLKS-1:0] blk_act,
    output logic [7:0]          mstat [NUM_MREG],
    output logic [7:0]          root
);
    localparam int PAD_BLKS = NUM_MREG * 8;

    logic [PAD_BLKS-1:0] act_pad;
    assign act_pad = PAD_BLKS'(blk_act);

    for (genvar m = 0; m < NUM_MREG; m++) begin : g_master
        assign mstat[m] = act_pad[m*8 +: 8];
    end

    // Flag each master whose status byte is nonzero
    always_comb begin
        root = '0;
        for (int m = 0; m < NUM_MREG; m++)
            root[m+1] = |mstat[m];
    end
endmodule

// File: rtl/irq_tree_ctrl.sv
`timescale 1ns/1ps
// Top of the indirect-access interrupt controller.
// Per-line state is reached through a block-select register; reads are combinational
// on reg_addr, writes take effect at the clock edge where reg_wr is high.
module irq_tree_ctrl
    import irq_tree_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic [NUM_LINES-1:0] line_in,
    output logic                 irq_out
);
    localparam int NUM_BLKS  = (NUM_LINES + LINES_PER_BLK - 1) / LINES_PER_BLK;
    localparam int PAD_LINES = NUM_BLKS * LINES_PER_BLK;

    logic [ADDR_W-1:0]    ofs;
    logic [7:0]           blk_sel_q;
    logic [2:0]           cfg_ptr_q;
    logic                 sel_ok;
    logic                 wr_bsel;
    logic                 wr_cfgreg;
    logic                 cfg_go;
    line_cfg_t            wr_cfg_w;
    logic [NUM_LINES-1:0] lvl_now;
    logic [NUM_LINES-1:0] lvl_prev;
    logic [PAD_LINES-1:0] pend_pad;
    logic [PAD_LINES-1:0] en_pad;
    logic [PAD_LINES-1:0] lvl_pad;
    line_cfg_t            cfg_pad [PAD_LINES];
    logic [NUM_BLKS-1:0]  blk_act;
    logic [7:0]           mstat [NUM_MREG];
    logic [7:0]           root;
    logic [NUM_LINES-1:0] pend_vec;
    logic [7:0]           sel_pend;
    logic [7:0]           sel_lvl;
    line_cfg_t            sel_cfg;

    assign ofs       = reg_addr - ADDR_W'(BASE_ADDR);
    assign sel_ok    = (blk_sel_q < 8'(NUM_BLKS));
    assign wr_bsel   = reg_wr && (ofs == ADDR_W'(OFS_BSEL));
    assign wr_cfgreg = reg_wr && (ofs == ADDR_W'(OFS_CFG));
    assign cfg_go    = wr_cfgreg && reg_wdata[CB_WE] && sel_ok;
    assign wr_cfg_w  = '{lvl:  reg_wdata[CB_LVL],
                         m_fe: reg_wdata[CB_MFE],
                         m_re: reg_wdata[CB_MRE]};

    irq_tree_sync #(.W(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (line_in),
        .q      (lvl_now),
        .q_prev (lvl_prev)
    );

    for (genvar n = 0; n < PAD_LINES; n++) begin : g_line
        if (n < NUM_LINES) begin : g_real
            logic hit;
            assign hit = cfg_go && (blk_sel_q == 8'(n / LINES_PER_BLK))
                      && (reg_wdata[CB_IDX +: 3] == 3'(n % LINES_PER_BLK));
            irq_tree_line u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_now  (lvl_now[n]),
                .lvl_prev (lvl_prev[n]),
                .wr_hit   (hit),
                .wr_cfg   (wr_cfg_w),
                .wr_clr   (reg_wdata[CB_CLR]),
                .cfg_q    (cfg_pad[n]),
                .pend_q   (pend_pad[n]),
                .enabled  (en_pad[n])
            );
            assign lvl_pad[n] = lvl_now[n];
        end else begin : g_pad
            assign cfg_pad[n]  = CFG_RESET;
            assign pend_pad[n] = 1'b0;
            assign en_pad[n]   = 1'b0;
            assign lvl_pad[n]  = 1'b0;
        end
    end

    for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
        assign blk_act[b] = |(pend_pad[b*8 +: 8] & en_pad[b*8 +: 8]);
    end

    irq_tree_summary #(.NUM_BLKS(NUM_BLKS)) u_sum (
        .blk_act (blk_act),
        .mstat   (mstat),
        .root    (root)
    );

    assign pend_vec = pend_pad[NUM_LINES-1:0];
    assign irq_out  = |root;

    // Block-select register
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_sel_q <= '0;
        else if (wr_bsel)
            blk_sel_q <= reg_wdata;
    end

    // Line index for configuration readback, taken from every config write
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_ptr_q <= '0;
        else if (wr_cfgreg)
            cfg_ptr_q <= reg_wdata[CB_IDX +: 3];
    end

    // Gather the selected block's pending, level and line setting
    always_comb begin
        sel_pend = '0;
        sel_lvl  = '0;
        sel_cfg  = '0;
        for (int b = 0; b < NUM_BLKS; b++) begin
            if (blk_sel_q == 8'(b)) begin
                sel_pend = pend_pad[b*8 +: 8];
                sel_lvl  = lvl_pad[b*8 +: 8];
                sel_cfg  = cfg_pad[b*8 + int'(cfg_ptr_q)];
            end
        end
    end

    // Read data multiplexer
    always_comb begin
        reg_rdata = '0;
        if (ofs == ADDR_W'(OFS_ROOT))
            reg_rdata = root;
        for (int m = 0; m < NUM_MREG; m++)
            if (ofs == ADDR_W'(OFS_MSTAT + m))
                reg_rdata = mstat[m];
        if (ofs == ADDR_W'(OFS_BSEL))
            reg_rdata = blk_sel_q;
        if (ofs == ADDR_W'(OFS_PEND))
            reg_rdata = sel_ok ? sel_pend : 8'h00;
        if (ofs == ADDR_W'(OFS_CFG))
            reg_rdata = sel_ok ? {1'b0, cfg_ptr_q, 1'b0, sel_cfg.m_re,
                                  sel_cfg.m_fe, sel_cfg.lvl} : 8'h00;
        if (ofs == ADDR_W'(OFS_LIVE))
            reg_rdata = sel_ok ? sel_lvl : 8'h00;
    end
endmodule

// File: rtl/irq_tree_chk.sv
`timescale 1ns/1ps
// Property checker for irq_tree_ctrl, attached by bind.
// Assumes reset is asserted from time zero and reg_addr is stable within a cycle.
module irq_tree_chk
    import irq_tree_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [7:0]           reg_wdata,
    input logic [7:0]           reg_rdata,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] pend_vec,
    input logic [7:0]           blk_sel
);
    localparam int NUM_BLKS = (NUM_LINES + LINES_PER_BLK - 1) / LINES_PER_BLK;

    logic [ADDR_W-1:0] ofs;
    logic              cfg_wr;
    assign ofs    = reg_addr - ADDR_W'(BASE_ADDR);
    assign cfg_wr = reg_wr && (ofs == ADDR_W'(OFS_CFG));

    p_root_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == ADDR_W'(OFS_ROOT)) |-> !reg_rdata[0]);

    p_irq_root_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == ADDR_W'(OFS_ROOT)) |-> (irq_out == (reg_rdata != 8'h00)));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ((pend_vec & $past(pend_vec)) == $past(pend_vec)));

    p_ignored_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !reg_wdata[CB_WE]) |=> ((pend_vec & $past(pend_vec)) == $past(pend_vec)));

    p_oor_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((ofs == ADDR_W'(OFS_PEND) || ofs == ADDR_W'(OFS_CFG) || ofs == ADDR_W'(OFS_LIVE))
         && (blk_sel >= 8'(NUM_BLKS))) |-> (reg_rdata == 8'h00));
endmodule

bind irq_tree_ctrl irq_tree_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .pend_vec  (pend_vec),
    .blk_sel   (blk_sel_q)
);

// File: tb/irq_tree_ctrl_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model stepped on every clock and compared
// against read data and the summary output each cycle.
module irq_tree_ctrl_bench;
    localparam int NL = 64;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NL-1:0] line_in = '0;
    logic          irq_out;
    logic [NL-1:0] lines = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    bit m_lvl [NL];
    bit m_mfe [NL];
    bit m_mre [NL];
    bit m_pend [NL];
    bit m_s1 [NL];
    bit m_s2 [NL];
    bit m_sp [NL];
    int m_bsel;
    int m_ptr;

    always #2.5 clk = ~clk;

    irq_tree_ctrl u_irq_tree_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .line_in   (line_in),
        .irq_out   (irq_out)
    );

    function automatic void model_reset();
        for (int n = 0; n < NL; n++) begin
            m_lvl[n] = 0; m_mfe[n] = 1; m_mre[n] = 1; m_pend[n] = 0;
            m_s1[n] = 0; m_s2[n] = 0; m_sp[n] = 0;
        end
        m_bsel = 0;
        m_ptr = 0;
    endfunction

    function automatic logic [7:0] model_master();
        logic [7:0] r = '0;
        for (int n = 0; n < NL; n++)
            if (m_pend[n] && !(m_mfe[n] && m_mre[n])) r[n/8] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        logic [7:0] r = '0;
        logic [7:0] ms = model_master();
        int ln;
        case (a)
            0: r = (ms != 0) ? 8'h02 : 8'h00;
            1: r = ms;
            5: r = 8'(m_bsel);
            6: if (m_bsel < NB) for (int i = 0; i < 8; i++) r[i] = m_pend[m_bsel*8+i];
            7: if (m_bsel < NB) begin
                ln = m_bsel*8 + m_ptr;
                r = {1'b0, 3'(m_ptr), 1'b0, m_mre[ln], m_mfe[ln], m_lvl[ln]};
            end
            8: if (m_bsel < NB) for (int i = 0; i < 8; i++) r[i] = m_s2[m_bsel*8+i];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic void model_edge(input logic wr, input logic [7:0] a,
                                       input logic [7:0] wd, input logic [NL-1:0] li);
        bit ev [NL];
        int tgt = -1;
        for (int n = 0; n < NL; n++) begin
            if (m_lvl[n])
                ev[n] = (m_s2[n] && !m_mre[n]) || (!m_s2[n] && !m_mfe[n]);
            else
                ev[n] = (m_s2[n] && !m_sp[n] && !m_mre[n]) || (!m_s2[n] && m_sp[n] && !m_mfe[n]);
        end
        if (wr && a == 7 && wd[7] && m_bsel < NB) tgt = m_bsel*8 + int'(wd[6:4]);
        for (int n = 0; n < NL; n++)
            m_pend[n] = ev[n] || (m_pend[n] && !(n == tgt && wd[3]));
        if (tgt >= 0) begin
            m_lvl[tgt] = wd[0]; m_mfe[tgt] = wd[1]; m_mre[tgt] = wd[2];
        end
        if (wr && a == 7) m_ptr = int'(wd[6:4]);
        if (wr && a == 5) m_bsel = int'(wd);
        for (int n = 0; n < NL; n++) begin
            m_sp[n] = m_s2[n]; m_s2[n] = m_s1[n]; m_s1[n] = li[n];
        end
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, got, exp);
        end
    endtask

    // One clock: drive at the falling edge, check, then advance the model
    task automatic step(input string tag, input logic wr, input logic [7:0] a,
                        input logic [7:0] wd);
        logic [7:0] exp_rd;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; line_in = lines;
        #1;
        exp_rd = model_read(a);
        chk(tag, "rdata", reg_rdata, exp_rd);
        chk("R10", "irq_out", {7'd0, irq_out}, {7'd0, (model_master() != 0)});
        @(posedge clk);
        model_edge(wr, a, wd, lines);
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input logic [7:0] a, input int k);
        for (int i = 0; i < k; i++) step(tag, 1'b0, a, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 and R5: reset values of every register
        for (int a = 0; a <= 9; a++) step("R1", 1'b0, 8'(a), 8'h00);
        step("R5", 1'b0, 8'd7, 8'h00);

        // R5: write line 3 of block 0 (rising only), read back; R4: ignored write
        step("R5", 1'b1, 8'd5, 8'h00);
        step("R5", 1'b1, 8'd7, 8'hB2);
        step("R5", 1'b0, 8'd7, 8'h00);
        step("R4", 1'b1, 8'd7, 8'h50);
        step("R4", 1'b0, 8'd7, 8'h00);

        // R6: rising edge on line 3, then clear, falling masked
        lines[3] = 1'b1;
        idle("R6", 8'd6, 5);
        step("R9", 1'b0, 8'd1, 8'h00);
        step("R1", 1'b0, 8'd0, 8'h00);
        step("R8", 1'b1, 8'd7, 8'hBA);
        idle("R8", 8'd6, 2);
        lines[3] = 1'b0;
        idle("R6", 8'd6, 5);
        // R6: falling only on line 4
        step("R6", 1'b1, 8'd7, 8'hC4);
        lines[4] = 1'b1;
        idle("R6", 8'd6, 5);
        lines[4] = 1'b0;
        idle("R6", 8'd6, 5);

        // R7: level active-high on line 9, clear while high re-pends
        step("R2", 1'b1, 8'd5, 8'h01);
        step("R7", 1'b1, 8'd7, 8'h93);
        lines[9] = 1'b1;
        idle("R7", 8'd6, 4);
        step("R8", 1'b1, 8'd7, 8'h9B);
        idle("R8", 8'd6, 2);
        lines[9] = 1'b0;
        idle("R7", 8'd6, 3);
        step("R8", 1'b1, 8'd7, 8'h9B);
        idle("R8", 8'd6, 3);
        // R7: active-low on line 10 fires while line is low
        step("R7", 1'b1, 8'd7, 8'hA5);
        idle("R7", 8'd6, 3);
        // R9: both masks on line 10 keep it pending but unsummarised
        step("R9", 1'b1, 8'd7, 8'hA6);
        step("R9", 1'b0, 8'd6, 8'h00);
        step("R9", 1'b0, 8'd1, 8'h00);
        step("R9", 1'b0, 8'd0, 8'h00);

        // R8: clear placed at every offset around a detected edge on line 5
        step("R8", 1'b1, 8'd5, 8'h00);
        step("R8", 1'b1, 8'd7, 8'hD0);
        for (int k = 0; k < 6; k++) begin
            lines[5] = ~lines[5];
            idle("R8", 8'd6, k);
            step("R8", 1'b1, 8'd7, 8'hD8);
            idle("R8", 8'd6, 4);
            step("R8", 1'b1, 8'd7, 8'hD8);
        end

        // R11: out-of-range selects read zero and ignore config writes
        step("R11", 1'b1, 8'd5, 8'h09);
        step("R11", 1'b0, 8'd6, 8'h00);
        step("R11", 1'b0, 8'd8, 8'h00);
        step("R11", 1'b1, 8'd7, 8'hF0);
        step("R11", 1'b0, 8'd7, 8'h00);
        step("R11", 1'b1, 8'd5, 8'hFF);
        step("R11", 1'b1, 8'd7, 8'hF0);
        step("R11", 1'b1, 8'd5, 8'h01);
        step("R11", 1'b1, 8'd7, 8'h70);
        step("R11", 1'b0, 8'd7, 8'h00);

        // R3 and R2: live levels and summary for line 45 (block 5 bit 5)
        step("R3", 1'b1, 8'd5, 8'h05);
        step("R2", 1'b1, 8'd7, 8'hD0);
        for (int k = 0; k < 4; k++) begin
            lines[45] = ~lines[45];
            lines[40] = (k % 2) == 0;
            idle("R3", 8'd8, 3);
            step("R2", 1'b0, 8'd1, 8'h00);
            step("R2", 1'b0, 8'd6, 8'h00);
            step("R2", 1'b1, 8'd7, 8'hD8);
        end

        // Seeded random traffic
        begin
            int seed = 7;
            void'($urandom(seed));
            for (int i = 0; i < 3000; i++) begin
                int sel = $urandom_range(0, 11);
                if (i % 6 == 0) lines[$urandom_range(0, NL-1)] ^= 1'b1;
                if (sel == 0)
                    step("R10", 1'b1, 8'd5, 8'($urandom_range(0, 9)));
                else if (sel <= 2)
                    step("R10", 1'b1, 8'd7, 8'($urandom_range(0, 255)));
                else
                    step("R10", 1'b0, 8'($urandom_range(0, 9)), 8'h00);
            end
        end

        finish_run();
    end
endmodule